// File: doc/BRIEF.md
# Repeated-Subtraction Integer Divider

This block divides one unsigned integer by another. It finds the quotient by subtracting the divisor from a running remainder once per clock and counting how many times it succeeds. A start pulse captures both operands while the divider is idle. The divider then runs until the remainder is smaller than the divisor, and ends with a one-cycle done pulse. Quotient and remainder are held on the outputs until the next accepted start.

A zero-detect stage on the divisor input catches division by zero. It raises the overflow flag and finishes the operation at once, without entering the subtraction loop. Because each subtraction takes one cycle, the latency depends on the data. Dividing the largest operand by one takes the most cycles, and busy stays high for that whole run. A start that arrives while the divider is busy is ignored.

Top module: `rsub_divider`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, done and overflow are 0 and quotient and remainder are 0.
- R2: A start seen on a clock edge while busy is 0 captures dividend and divisor. With a nonzero divisor, busy is 1 after that edge, quotient is 0 and remainder equals the captured dividend.
- R3: For a nonzero divisor, the operation ends with quotient = floor(dividend / divisor) and remainder = dividend mod divisor. This includes a dividend of zero and a dividend smaller than the divisor.
- R4: For a nonzero divisor, done is 1 after exactly floor(dividend / divisor) + 1 clock edges following the capture edge. Busy stays 1 from the capture edge until done rises.
- R5: A zero divisor sets overflow to 1 and makes done 1 directly after the capture edge. Busy stays 0, quotient is 0 and remainder equals the dividend.
- R6: Done is a single-cycle pulse. Quotient, remainder and overflow keep their values from then until the next accepted start.
- R7: A start asserted while busy is 1 is ignored. The running operation completes with the operands captured at its own start.
- R8: Overflow is cleared by the next accepted start with a nonzero divisor.
- R9: Busy and done are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; honoured only while idle |
| dividend | input | W (16) | Unsigned dividend, captured at start |
| divisor | input | W (16) | Unsigned divisor, captured at start |
| busy | output | 1 | Subtraction loop in progress |
| done | output | 1 | One-cycle pulse when results are ready |
| overflow | output | 1 | Last accepted division had a zero divisor |
| quotient | output | W (16) | Number of successful subtractions |
| remainder | output | W (16) | Running or final remainder |

## Verification
The bench builds the divider with its default width of 16 bits. At that width the worst-case run is short enough to test: 65535 divided by 1 takes 65536 edges after capture. The bench measures that run end to end, together with the exact cycle count of every division. The same width also covers operands at both ends of the 16-bit range, divisors equal to or just below the dividend, and a zero divisor followed by a normal division.

// File: rtl/rsub_divider.sv
module rsub_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         overflow,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);

  logic [W-1:0] dvs_q;
  logic         run_q;
  logic [W:0]   diff;
  logic         accept, dvs_zero, stop;

  assign diff     = {1'b0, remainder} - {1'b0, dvs_q};
  assign dvs_zero = (divisor == '0);
  assign stop     = diff[W] || (remainder == '0);
  assign accept   = start && !run_q;
  assign busy     = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q     <= '0;
      run_q     <= 1'b0;
      done      <= 1'b0;
      overflow  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        remainder <= dividend;
        quotient  <= '0;
        dvs_q     <= divisor;
        overflow  <= dvs_zero;
        run_q     <= !dvs_zero;
        done      <= dvs_zero;
      end else if (run_q) begin
        if (stop) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          remainder <= diff[W-1:0];
          quotient  <= quotient + 1'b1;
        end
      end
    end
  end

endmodule

module rsub_divider_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         overflow,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(overflow)));

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && divisor == '0) |=> (done && overflow && !busy));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && divisor != '0) |=> (busy && !overflow && quotient == '0 && remainder == $past(dividend)));

  // R7
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (quotient == $past(quotient) || quotient == $past(quotient) + 1'b1));

endmodule

bind rsub_divider rsub_divider_chk #(.W(W)) u_chk (.*);

// File: tb/tb_rsub_divider.sv
module tb_rsub_divider;
  localparam int W = 16;
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {16'd100,   16'd7},
    {16'd0,     16'd5},
    {16'd3,     16'd9},
    {16'd255,   16'd255},
    {16'd1000,  16'd1},
    {16'd65535, 16'd256},
    {16'd12345, 16'd0},
    {16'd50000, 16'd49999}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, overflow;
  logic [W-1:0] quotient, remainder;
  int n_chk = 0, n_fail = 0, wd = 0;

  rsub_divider #(.W(W)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit interfere);
    int cyc;
    logic [W-1:0] eq, er;
    eq = (b == 0) ? '0 : a / b;
    er = (b == 0) ? a : a % b;
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (b != 0) chk("R2 busy after capture", busy, 1);
    else chk("R5 no busy on zero divisor", busy, 0);
    while (!done && cyc < 70000) begin
      if (interfere && cyc == 5) begin
        start = 1'b1; dividend = 16'd7; divisor = 16'd1;
      end else start = 1'b0;
      if (b != 0) chk("R4 busy during loop", busy, 1);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(interfere ? "R7 quotient after ignored start" : "R3 quotient", quotient, eq);
    chk(interfere ? "R7 remainder after ignored start" : "R3 remainder", remainder, er);
    chk((b == 0) ? "R5 overflow set" : "R8 overflow clear", overflow, (b == 0));
    chk((b == 0) ? "R5 done latency" : "R4 done latency", cyc, (b == 0) ? 1 : eq + 2);
    chk("R9 busy with done", busy, 0);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk("R6 quotient held", quotient, eq);
    chk("R6 remainder held", remainder, er);
    chk("R6 overflow held", overflow, (b == 0));
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 overflow in reset", overflow, 0);
    chk("R1 quotient in reset", quotient, 0);
    chk("R1 remainder in reset", remainder, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {busy, done, overflow}, 0);
    chk("R1 quotient after reset", quotient, 0);

    for (int i = 0; i < NV; i++)
      do_div(VEC[i][31:16], VEC[i][15:0], 1'b0);

    do_div(16'd200, 16'd3, 1'b1);
    do_div(16'd9, 16'd0, 1'b0);
    do_div(16'd65535, 16'd1, 1'b0);
    do_div(16'd1, 16'd65535, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule